// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on the write side of a 32-bit host register bus, in front of a bank of 128-bit registers. Each wide register is written as four 32-bit dwords. The collector gathers them, one dword per bus write, and sends the whole 128-bit value to the register bank in a single strobe. The register therefore never shows a mix of old and new dwords. The collector follows one target register at a time.

A short parameter list marks some register indices as doorbells. These are write-only pointer-update registers that the host writes without taking a lock. A write to the top dword of a doorbell always commits. If the low three dwords have not all been collected for that same register, they are sent as zero. A doorbell write to a lower dword is dropped when the collector is already busy with a different register.

The byte address splits into a register index (bits above 3) and a dword lane (bits 3:2). Bits 1:0 are ignored. A commit shows up on the output one clock after the write that caused it.

Top module: `wide_reg_collector`

## Requirements
- R1: While reset is high, and in the first cycle after it, `commit_valid` is 0. The collector starts empty.
- R2: For a normal register, the write that supplies the last missing dword is followed, exactly one clock later, by a one-cycle `commit_valid` pulse. `commit_idx` carries the register index and `commit_data` the four collected dwords, with lane n in bits 32n+31:32n. The dwords may arrive in any lane order.
- R3: A normal-register write that leaves any lane of the target still missing produces no commit.
- R4: A normal-register write whose index differs from the register currently held restarts the collector with the new register. Dwords already collected for the old register are dropped.
- R5: A write to lane 3 of a doorbell index commits one clock later, every time. `commit_data` holds the collected lanes 0..2 only if all three were collected for that same register. Otherwise bits 95:0 are zero. Bits 127:96 always carry the written dword.
- R6: A doorbell write to lane 0, 1 or 2 while the collector holds data for a different register is discarded. The held register and its dwords are kept unchanged.
- R7: After every commit the collector is empty, so the next commit of a normal register needs all four lanes written anew.
- R8: An index counts as a doorbell only if it appears in `DB_LIST`, which defaults to the indices 5 and 9. A lane-3 write to any other index follows the normal rules.
- R9: The register index is `wr_addr[ADDR_W-1:4]` and the lane is `wr_addr[3:2]`. Bits 1:0 have no effect.
- R10: Writing the same lane twice before completion keeps the later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host dword write valid this cycle |
| wr_addr | input | ADDR_W | Byte address of the dword written |
| wr_data | input | 32 | Dword value |
| commit_valid | output | 1 | One-cycle strobe toward the register bank |
| commit_idx | output | ADDR_W-4 | Index of the register being committed |
| commit_data | output | 128 | Full value written to that register |

## Verification
The bench drives the following write patterns:
- In-order and shuffled lane orders on normal registers. These show that lane placement comes from the address and not from arrival order.
- A repeated lane, which tells last-write-wins apart from first-write-wins.
- Interleaved writes to two normal registers, which separate restart from merge.
- Doorbell sequences: a lone top write, a complete write, and a partial write followed by the top. These tell the full value apart from zero fill.
- Doorbell low writes that arrive while a normal register is held. These must leave that register's partial data intact.
- A long pseudo-random mix of all of these, with idle cycles between writes. A behavioural model predicts the output for every cycle of the run.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
   localparam int DWORD_W  = 32;
   localparam int LANES    = 4;
   localparam int WIDE_W   = DWORD_W * LANES;
   localparam int LANE_W   = $clog2(LANES);
   localparam int TOP_LANE = LANES - 1;

   typedef logic [DWORD_W-1:0] dword_t;
   typedef logic [WIDE_W-1:0]  wide_t;
   typedef logic [LANES-1:0]   lane_mask_t;
   typedef logic [LANE_W-1:0]  lane_t;
endpackage

// File: rtl/wrc_db_match.sv
module wrc_db_match #(
   parameter int IDX_W  = 4,
   parameter int NUM_DB = 2,
   parameter logic [NUM_DB*IDX_W-1:0] DB_LIST = '0
) (
   input  logic [IDX_W-1:0] idx,
   output logic             is_db
);
   logic [NUM_DB-1:0] hit;

   for (genvar i = 0; i < NUM_DB; i++) begin : g_cmp
      assign hit[i] = (idx == DB_LIST[i*IDX_W +: IDX_W]);
   end

   assign is_db = |hit;
endmodule

// File: rtl/wrc_collect.sv
module wrc_collect
   import wrc_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  lane_t            wr_lane,
   input  dword_t           wr_data,
   input  logic             is_db,
   output logic             fire,
   output logic [IDX_W-1:0] fire_idx,
   output wide_t            fire_data
);
   lane_mask_t       mask_q, mask_d, lane_bit, merged_mask;
   logic [IDX_W-1:0] base_q, base_d;
   dword_t           slot_q [LANES];
   logic             store;
   logic             held, same, full, top_db;
   wide_t            merged;

   assign lane_bit    = lane_mask_t'(1) << wr_lane;
   assign held        = |mask_q;
   assign same        = held && (base_q == wr_idx);
   assign merged_mask = (same ? mask_q : '0) | lane_bit;
   assign full        = &merged_mask;
   assign top_db      = is_db && (wr_lane == lane_t'(TOP_LANE));

   for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign merged[l*DWORD_W +: DWORD_W] =
         (wr_lane == lane_t'(l)) ? wr_data : slot_q[l];
   end

   always_comb begin
      mask_d    = mask_q;
      base_d    = base_q;
      store     = 1'b0;
      fire      = 1'b0;
      fire_data = merged;
      if (wr_en) begin
         if (top_db) begin
            fire   = 1'b1;
            if (!full)
               fire_data = {wr_data, {(WIDE_W-DWORD_W){1'b0}}};
            mask_d = '0;
            base_d = '0;
         end else if (is_db && held && !same) begin
            mask_d = mask_q;
         end else if (full) begin
            fire   = 1'b1;
            mask_d = '0;
            base_d = '0;
         end else begin
            mask_d = merged_mask;
            base_d = wr_idx;
            store  = 1'b1;
         end
      end
   end

   assign fire_idx = wr_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= '0;
         base_q <= '0;
         for (int l = 0; l < LANES; l++) slot_q[l] <= '0;
      end else begin
         mask_q <= mask_d;
         base_q <= base_d;
         if (store) slot_q[wr_lane] <= wr_data;
      end
   end

   AST_DB_DISCARD_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && is_db && !top_db && held && !same) |=> ($stable(mask_q) && $stable(base_q))); // R6

   AST_EMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
      fire |=> (mask_q == '0)); // R7
endmodule

// File: rtl/wrc_commit.sv
module wrc_commit
   import wrc_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fire,
   input  logic [IDX_W-1:0] fire_idx,
   input  wide_t            fire_data,
   output logic             commit_valid,
   output logic [IDX_W-1:0] commit_idx,
   output wide_t            commit_data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         commit_valid <= 1'b0;
         commit_idx   <= '0;
         commit_data  <= '0;
      end else begin
         commit_valid <= fire;
         if (fire) begin
            commit_idx  <= fire_idx;
            commit_data <= fire_data;
         end
      end
   end
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
   import wrc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_DB = 2,
   parameter logic [NUM_DB*(ADDR_W-4)-1:0] DB_LIST = {4'd9, 4'd5}
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   output logic                commit_valid,
   output logic [ADDR_W-5:0]   commit_idx,
   output logic [127:0]        commit_data
);
   localparam int IDX_W = ADDR_W - 4;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must leave at least one register index bit");
   end
   if (NUM_DB < 1) begin : g_bad_list
      $error("NUM_DB must be at least one");
   end
   if (WIDE_W != 128) begin : g_bad_wide
      $error("collector is built for 128-bit registers");
   end

   logic [IDX_W-1:0] wr_idx;
   lane_t            wr_lane;
   logic             is_db;
   logic             fire;
   logic [IDX_W-1:0] fire_idx;
   wide_t            fire_data;
   logic             unused_byte_bits;

   assign wr_idx           = wr_addr[ADDR_W-1:4];
   assign wr_lane          = wr_addr[3:2];
   assign unused_byte_bits = ^wr_addr[1:0];

   wrc_db_match #(.IDX_W(IDX_W), .NUM_DB(NUM_DB), .DB_LIST(DB_LIST)) u_match (
      .idx   (wr_idx),
      .is_db (is_db)
   );

   wrc_collect #(.IDX_W(IDX_W)) u_collect (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_lane   (wr_lane),
      .wr_data   (wr_data),
      .is_db     (is_db),
      .fire      (fire),
      .fire_idx  (fire_idx),
      .fire_data (fire_data)
   );

   wrc_commit #(.IDX_W(IDX_W)) u_commit (
      .clk          (clk),
      .rst          (rst),
      .fire         (fire),
      .fire_idx     (fire_idx),
      .fire_data    (fire_data),
      .commit_valid (commit_valid),
      .commit_idx   (commit_idx),
      .commit_data  (commit_data)
   );

   AST_COMMIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
      commit_valid |-> $past(wr_en)); // R2

   AST_DB_TOP_COMMITS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && is_db && wr_lane == lane_t'(TOP_LANE)) |=> (commit_valid && commit_idx == $past(wr_idx))); // R5
endmodule

// File: tb/wide_reg_collector_tb.sv
module wide_reg_collector_tb;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic         wr_en;
   logic [7:0]   wr_addr;
   logic [31:0]  wr_data;
   logic         commit_valid;
   logic [3:0]   commit_idx;
   logic [127:0] commit_data;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 0;

   // behavioural model state
   int          m_base = -1;
   bit [3:0]    m_mask = 0;
   logic [31:0] m_slot [4];
   bit          exp_v;
   int          exp_idx;
   logic [127:0] exp_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   wide_reg_collector u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit_valid(commit_valid), .commit_idx(commit_idx), .commit_data(commit_data)
   );

   function automatic bit is_bell(int idx);
      return (idx == 5) || (idx == 9);
   endfunction

   function automatic void clear_model();
      m_base = -1;
      m_mask = 0;
   endfunction

   function automatic void model(int idx, int lane, logic [31:0] d);
      exp_v = 0;
      if (is_bell(idx) && lane == 3) begin
         exp_v = 1; exp_idx = idx;
         if (m_base == idx && m_mask == 4'b0111)
            exp_data = {d, m_slot[2], m_slot[1], m_slot[0]};
         else
            exp_data = {d, 96'b0};
         clear_model();
      end else if (is_bell(idx)) begin
         if (!(m_base != -1 && m_base != idx)) begin
            m_base = idx; m_slot[lane] = d; m_mask[lane] = 1'b1;
         end
      end else begin
         if (m_base != -1 && m_base != idx) m_mask = 0;
         m_base = idx; m_slot[lane] = d; m_mask[lane] = 1'b1;
         if (m_mask == 4'hF) begin
            exp_v = 1; exp_idx = idx;
            exp_data = {m_slot[3], m_slot[2], m_slot[1], m_slot[0]};
            clear_model();
         end
      end
   endfunction

   task automatic compare(string req);
      total++;
      if (commit_valid !== exp_v) begin
         bad++;
         $display("FAIL %s: commit_valid=%0b expected %0b", req, commit_valid, exp_v);
      end else if (exp_v && (commit_idx !== exp_idx[3:0] || commit_data !== exp_data)) begin
         bad++;
         $display("FAIL %s: idx=%0d data=%h expected idx=%0d data=%h",
                  req, commit_idx, commit_data, exp_idx, exp_data);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic wr(int idx, int lane, logic [31:0] d, string req, int low = 0);
      wr_en   = 1'b1;
      wr_addr = {idx[3:0], lane[1:0], low[1:0]};
      wr_data = d;
      model(idx, lane, d);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      compare(req);
   endtask

   task automatic idle(string req);
      wr_en = 1'b0;
      exp_v = 0;
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: run still busy, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit [15:0] lfsr;
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      for (int l = 0; l < 4; l++) m_slot[l] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_v = 0; compare("R1 in reset");
      rst = 1'b0;
      idle("R1 after reset");

      // R2 / R3: in-order lanes on a normal register
      wr(2, 0, 32'h1111_0000, "R3 lane0");
      wr(2, 1, 32'h1111_0001, "R3 lane1");
      wr(2, 2, 32'h1111_0002, "R3 lane2");
      wr(2, 3, 32'h1111_0003, "R2 in-order commit");
      idle("R2 strobe one cycle");

      // R9: shuffled order, byte bits set
      wr(7, 3, 32'hA3A3_A3A3, "R9 lane3", 3);
      wr(7, 1, 32'hA1A1_A1A1, "R9 lane1", 1);
      wr(7, 0, 32'hA0A0_A0A0, "R9 lane0", 2);
      wr(7, 2, 32'hA2A2_A2A2, "R9 shuffled commit");

      // R10: repeated lane
      wr(1, 0, 32'hDEAD_0000, "R10 first");
      wr(1, 0, 32'hBEEF_0000, "R10 second");
      wr(1, 1, 32'h0000_0011, "R10 lane1");
      wr(1, 2, 32'h0000_0022, "R10 lane2");
      wr(1, 3, 32'h0000_0033, "R10 last wins");

      // R4: restart on foreign normal register
      wr(3, 0, 32'h3000_0000, "R4 a0");
      wr(3, 1, 32'h3000_0001, "R4 a1");
      wr(4, 0, 32'h4000_0000, "R4 b0 restarts");
      wr(3, 2, 32'h3000_0002, "R4 a2 restarts");
      wr(3, 3, 32'h3000_0003, "R4 a3 no commit");
      wr(3, 0, 32'h3100_0000, "R4 a0 again");
      wr(3, 1, 32'h3100_0001, "R4 complete");

      // R7: empty after commit
      wr(2, 0, 32'h7000_0000, "R7 l0");
      wr(2, 1, 32'h7000_0001, "R7 l1");
      wr(2, 2, 32'h7000_0002, "R7 no stale lane");
      wr(2, 3, 32'h7000_0003, "R7 commit");

      // R5: doorbells
      wr(5, 3, 32'h5555_AAAA, "R5 lone top zero fill");
      wr(5, 0, 32'h5000_0000, "R5 f0");
      wr(5, 1, 32'h5000_0001, "R5 f1");
      wr(5, 2, 32'h5000_0002, "R5 f2");
      wr(5, 3, 32'h5000_0003, "R5 full value");
      wr(9, 0, 32'h9000_0000, "R5 partial");
      wr(9, 3, 32'h9000_0003, "R5 partial zero fill");
      wr(9, 3, 32'h9100_0003, "R5 back to back");

      // R6: discard while a normal register is held
      wr(2, 0, 32'h6000_0000, "R6 hold");
      wr(5, 1, 32'hBAD0_0001, "R6 discarded");
      wr(9, 2, 32'hBAD0_0002, "R6 discarded");
      wr(2, 1, 32'h6000_0001, "R6 l1");
      wr(2, 2, 32'h6000_0002, "R6 l2");
      wr(2, 3, 32'h6000_0003, "R6 kept data");
      wr(2, 0, 32'h6100_0000, "R6 hold2");
      wr(5, 3, 32'h6100_5555, "R5 top over foreign");
      wr(2, 1, 32'h6100_0001, "R7 cleared by bell");
      wr(2, 2, 32'h6100_0002, "R7 cleared by bell");
      wr(2, 3, 32'h6100_0003, "R7 still missing lane0");

      // R8: non-listed index with top lane
      wr(6, 3, 32'h8000_0003, "R8 not a bell");
      wr(6, 0, 32'h8000_0000, "R8 l0");
      wr(6, 1, 32'h8000_0001, "R8 l1");
      wr(6, 2, 32'h8000_0002, "R8 normal commit");

      // pseudo-random mix, R2..R10
      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         int idx;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[3:2])
            2'd0: idx = 2;
            2'd1: idx = 5;
            2'd2: idx = 6;
            default: idx = 9;
         endcase
         if (lfsr[7:5] == 3'd0) idle("R3 random idle");
         else wr(idx, int'(lfsr[1:0] ^ lfsr[9:8]), {lfsr, ~lfsr}, "R2 random mix", int'(lfsr[11:10]));
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule